// File: doc/BRIEF.md
# Horizontal Register Clock Sequencer

This block generates the three transport clocks and the reset-gate pulse for the horizontal output register of a frame-transfer CCD. It runs from a clock six times the pixel rate. A sub-phase counter splits each pixel period into six slots, and every clock edge is placed on one of those slots. A run gate from the line timing starts and stops the transport. A direction bit, captured when the gate rises, selects which end of the register the charge is moved toward.

Alongside the clocks, the block gives a one-cycle strobe for each pixel. The strobe carries the pixel's column number and a two-bit class code. Downstream video logic uses the class to tell apart four kinds of pixel: the leading dummy cells, the shielded black-reference columns, the overscan columns and the active image. A line reads out in this fixed order: 7 dummy, 20 black, 4 overscan, 1024 active, 4 overscan, 20 black.

Top module: `ccd_hreg_sequencer`

## Requirements
- R1: In every cycle, either one or two of the three transport clocks are high. Each clock is high for 3 of the 6 sub-phases (half duty), and each clock is offset from the next by 2 sub-phases.
- R2: Sub-phases are numbered 0 to 5 from the start of a pixel. With the direction bit captured low, C1 is high in sub-phases 0, 1 and 2, C2 in 2, 3 and 4, and C3 in 4, 5 and 0.
- R3: With the direction bit captured high, C1 and C2 exchange waveforms and C3 is unchanged. The direction bit is sampled only on the cycle the run gate rises; changes while a line runs have no effect.
- R4: While running, `rg` is high for exactly one cycle per pixel, in sub-phase 0. It is never high in the same cycle as `pix_valid`.
- R5: While running, `pix_valid` is high for one cycle in sub-phase 5 of every pixel. `col_idx` gives the pixel's position in the line, counting from 0 and rising by one per pixel.
- R6: `pix_class` follows the line order, with codes 00 dummy, 01 black, 10 overscan and 11 active. Columns 0–6 are dummy, 7–26 black, 27–30 overscan, 31–1054 active, 1055–1058 overscan and 1059–1078 black.
- R7: Columns from 1079 upward, past the defined sequence, are reported as dummy (00). The column count saturates at its maximum value and does not wrap.
- R8: While the run gate is low, C1, C2 and C3 hold their levels, and `rg` and `pix_valid` stay low.
- R9: After a rising edge of the run gate, the next cycle is sub-phase 0 of column 0. In that cycle `rg` is high and the clocks show their sub-phase-0 levels.
- R10: After reset, C1=1, C2=0, C3=1, `rg`=0, `pix_valid`=0 and `col_idx`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, six times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run gate from line timing; high lets the transport advance |
| mirror | input | 1 | Readout direction, sampled on the rising edge of `run` |
| c1 | output | 1 | Transport clock phase 1 |
| c2 | output | 1 | Transport clock phase 2 |
| c3 | output | 1 | Transport clock phase 3 |
| rg | output | 1 | Reset-gate pulse, one per pixel |
| pix_valid | output | 1 | Per-pixel strobe in the last sub-phase |
| pix_class | output | 2 | Class of the current column (00 dummy, 01 black, 10 overscan, 11 active) |
| col_idx | output | COL_W | Column number within the line |

## Verification
Some behaviour is checked by assertions on every cycle. These cover the count of transport clocks that are high, the single reset-gate cycle and its separation from the strobe, the frozen clocks and silent strobes while the gate is low, the restart at column 0 after the gate rises, and the one-step column advance. Other behaviour needs the bench's scenarios, which compare the whole waveform against an independent model. These are the exact position of each waveform for both directions, the correct class over a full line and past its end, a pause that falls in the middle of a pixel, and a direction change during a line that must be ignored.

// File: rtl/ccd_hreg_pkg.sv
`timescale 1ns/1ps
package ccd_hreg_pkg;

    localparam int NUM_PHASES = 3;

    typedef enum logic [1:0] {
        PCLS_DUMMY    = 2'b00,
        PCLS_BLACK    = 2'b01,
        PCLS_OVERSCAN = 2'b10,
        PCLS_ACTIVE   = 2'b11
    } pix_class_e;

    typedef struct packed {
        logic ph_a;
        logic ph_b;
        logic ph_c;
    } tri_phase_t;

    // Level of a half-duty phase whose high window opens at sub-phase 'start'.
    function automatic logic phase_high(input int sub, input int start, input int subs);
        int rel;
        rel = (sub + subs - start) % subs;
        return (rel < (subs / 2));
    endfunction

    // Class of a column in the fixed line order, dummy past the end.
    function automatic pix_class_e class_of(input int n, input int nd, input int nb,
                                            input int no, input int na);
        pix_class_e c;
        if (n < nd)                          c = PCLS_DUMMY;
        else if (n < nd + nb)                c = PCLS_BLACK;
        else if (n < nd + nb + no)           c = PCLS_OVERSCAN;
        else if (n < nd + nb + no + na)      c = PCLS_ACTIVE;
        else if (n < nd + nb + 2*no + na)    c = PCLS_OVERSCAN;
        else if (n < nd + 2*nb + 2*no + na)  c = PCLS_BLACK;
        else                                 c = PCLS_DUMMY;
        return c;
    endfunction

endpackage

// File: rtl/ccd_hreg_tick.sv
`timescale 1ns/1ps
module ccd_hreg_tick
    import ccd_hreg_pkg::*;
#(
    parameter int SUBS  = 6,
    parameter int SUB_W = $clog2(SUBS),
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [SUB_W-1:0] sub,
    output logic [COL_W-1:0] col,
    output logic             act,
    output logic             line_start,
    output logic             px_end
);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBS - 1);
    localparam logic [COL_W-1:0] COL_MAX  = '1;

    logic run_q;

    assign line_start = run & ~run_q;
    assign px_end     = act & (sub == SUB_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            sub   <= '0;
            col   <= '0;
            act   <= 1'b0;
        end else begin
            run_q <= run;
            if (line_start) begin
                sub <= '0;
                col <= '0;
                act <= 1'b1;
            end else if (run) begin
                act <= 1'b1;
                if (sub == SUB_LAST) begin
                    sub <= '0;
                    if (col != COL_MAX)
                        col <= col + 1'b1;
                end else begin
                    sub <= sub + 1'b1;
                end
            end else begin
                act <= 1'b0;
            end
        end
    end

    AST_SUB_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(sub) < SUBS); // R5
    AST_RESTART_COL: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (col == '0 && sub == '0 && act)); // R9
    AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
        (px_end && run && col != COL_MAX) |=> (col == $past(col) + 1'b1)); // R5
    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(sub) && !act)); // R8

endmodule

// File: rtl/ccd_hreg_phase_gen.sv
`timescale 1ns/1ps
module ccd_hreg_phase_gen
    import ccd_hreg_pkg::*;
#(
    parameter int SUBS  = 6,
    parameter int SUB_W = $clog2(SUBS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SUB_W-1:0] sub,
    input  logic             act,
    input  logic             line_start,
    input  logic             mirror_in,
    output tri_phase_t       phases,
    output logic             rg
);
    localparam int STEP = SUBS / NUM_PHASES;

    logic [NUM_PHASES-1:0] lvl;
    logic                  mir_q;

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_ph
        assign lvl[g] = phase_high(32'(sub), g * STEP, SUBS);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mir_q <= 1'b0;
        else if (line_start)
            mir_q <= mirror_in;
    end

    always_comb begin
        phases.ph_a = mir_q ? lvl[1] : lvl[0];
        phases.ph_b = mir_q ? lvl[0] : lvl[1];
        phases.ph_c = lvl[2];
    end

    assign rg = act & (sub == '0);

    AST_PHASE_COUNT: assert property (@(posedge clk) disable iff (rst)
        ($countones(phases) >= 1 && $countones(phases) <= 2)); // R1
    AST_RG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rg |=> !rg); // R4

endmodule

// File: rtl/ccd_hreg_classify.sv
`timescale 1ns/1ps
module ccd_hreg_classify
    import ccd_hreg_pkg::*;
#(
    parameter int COL_W      = 11,
    parameter int N_DUMMY    = 7,
    parameter int N_BLACK    = 20,
    parameter int N_OVERSCAN = 4,
    parameter int N_ACTIVE   = 1024
) (
    input  logic [COL_W-1:0] col,
    output pix_class_e       cls
);
    always_comb begin
        cls = class_of(32'(col), N_DUMMY, N_BLACK, N_OVERSCAN, N_ACTIVE);
    end
endmodule

// File: rtl/ccd_hreg_sequencer.sv
`timescale 1ns/1ps
module ccd_hreg_sequencer
    import ccd_hreg_pkg::*;
#(
    parameter int SUBS       = 6,
    parameter int COL_W      = 11,
    parameter int N_DUMMY    = 7,
    parameter int N_BLACK    = 20,
    parameter int N_OVERSCAN = 4,
    parameter int N_ACTIVE   = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             mirror,
    output logic             c1,
    output logic             c2,
    output logic             c3,
    output logic             rg,
    output logic             pix_valid,
    output logic [1:0]       pix_class,
    output logic [COL_W-1:0] col_idx
);
    localparam int SUB_W    = $clog2(SUBS);
    localparam int LINE_LEN = N_DUMMY + 2*N_BLACK + 2*N_OVERSCAN + N_ACTIVE;

    logic [SUB_W-1:0] sub;
    logic [COL_W-1:0] col;
    logic             act;
    logic             line_start;
    logic             px_end;
    tri_phase_t       phases;
    pix_class_e       cls;

    ccd_hreg_tick #(.SUBS(SUBS), .SUB_W(SUB_W), .COL_W(COL_W)) u_tick (
        .clk(clk), .rst(rst), .run(run),
        .sub(sub), .col(col), .act(act),
        .line_start(line_start), .px_end(px_end)
    );

    ccd_hreg_phase_gen #(.SUBS(SUBS), .SUB_W(SUB_W)) u_phase (
        .clk(clk), .rst(rst), .sub(sub), .act(act),
        .line_start(line_start), .mirror_in(mirror),
        .phases(phases), .rg(rg)
    );

    ccd_hreg_classify #(
        .COL_W(COL_W), .N_DUMMY(N_DUMMY), .N_BLACK(N_BLACK),
        .N_OVERSCAN(N_OVERSCAN), .N_ACTIVE(N_ACTIVE)
    ) u_class (
        .col(col), .cls(cls)
    );

    assign c1        = phases.ph_a;
    assign c2        = phases.ph_b;
    assign c3        = phases.ph_c;
    assign pix_valid = px_end;
    assign pix_class = cls;
    assign col_idx   = col;

    AST_PAUSE_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable({c1, c2, c3}) && !rg && !pix_valid)); // R8
    AST_RG_VALID_APART: assert property (@(posedge clk) disable iff (rst)
        !(rg && pix_valid)); // R4
    AST_TAIL_DUMMY: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && 32'(col_idx) >= LINE_LEN) |-> (pix_class == 2'b00)); // R7

endmodule

// File: tb/ccd_hreg_sequencer_tb.sv
`timescale 1ns/1ps
module ccd_hreg_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        mirror = 1'b0;
    logic        c1, c2, c3, rg, pix_valid;
    logic [1:0]  pix_class;
    logic [10:0] col_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int exp_col_q[$];
    int exp_cls_q[$];

    int m_sub, m_col;
    bit m_act, m_mir, m_runq;

    always #4 clk = ~clk;

    ccd_hreg_sequencer u_dut (
        .clk(clk), .rst(rst), .run(run), .mirror(mirror),
        .c1(c1), .c2(c2), .c3(c3), .rg(rg), .pix_valid(pix_valid),
        .pix_class(pix_class), .col_idx(col_idx)
    );

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
        end
    endtask

    // Line order from R6 and R7.
    function automatic int ref_class(input int n);
        if (n < 7)    return 0;
        if (n < 27)   return 1;
        if (n < 31)   return 2;
        if (n < 1055) return 3;
        if (n < 1059) return 2;
        if (n < 1079) return 1;
        return 0;
    endfunction

    // Normal-direction windows from R2.
    function automatic bit win1(input int s); return (s <= 2);            endfunction
    function automatic bit win2(input int s); return (s >= 2 && s <= 4);  endfunction
    function automatic bit win3(input int s); return (s >= 4 || s == 0);  endfunction

    // Monitor: compares ports with the requirement model, pops the scoreboard.
    always @(negedge clk) begin
        if (rst) begin
            m_sub = 0; m_col = 0; m_act = 0; m_mir = 0; m_runq = 0;
        end else begin
            bit e1, e2, e3, erg, ev;
            string ptag;
            e1 = m_mir ? win2(m_sub) : win1(m_sub);
            e2 = m_mir ? win1(m_sub) : win2(m_sub);
            e3 = win3(m_sub);
            ptag = !m_act ? "R8" : ((m_mir || mirror != m_mir) ? "R3" : "R2");
            chk(c1 == e1, ptag, c1, e1);
            chk(c2 == e2, ptag, c2, e2);
            chk(c3 == e3, ptag, c3, e3);
            chk((c1 + c2 + c3) >= 1 && (c1 + c2 + c3) <= 2, "R1", c1 + c2 + c3, 1);
            erg = m_act && m_sub == 0;
            chk(rg == erg, (erg && m_col == 0) ? "R9" : (m_act ? "R4" : "R8"), rg, erg);
            ev = m_act && m_sub == 5;
            chk(pix_valid == ev, m_act ? "R5" : "R8", pix_valid, ev);
            chk(int'(col_idx) == m_col, "R5", col_idx, m_col);
            if (pix_valid) begin
                if (exp_col_q.size() == 0) begin
                    chk(1'b0, "R5", 1, 0);
                end else begin
                    int ec, ek;
                    ec = exp_col_q.pop_front();
                    ek = exp_cls_q.pop_front();
                    chk(int'(col_idx) == ec, "R5", col_idx, ec);
                    chk(int'(pix_class) == ek, (ec >= 1079) ? "R7" : "R6", pix_class, ek);
                end
            end
            // advance the model with the inputs the next edge samples
            if (run && !m_runq) begin
                m_sub = 0; m_col = 0; m_act = 1; m_mir = mirror;
            end else if (run) begin
                m_act = 1;
                if (m_sub == 5) begin
                    m_sub = 0;
                    if (m_col != 2047) m_col++;
                end else begin
                    m_sub++;
                end
            end else begin
                m_act = 0;
            end
            m_runq = run;
        end
    end

    // Driver: queues expected pixels, then opens the run gate.
    task automatic run_line(input bit mir, input int npix, input int extra, input int flip_at);
        for (int j = 0; j < npix; j++) begin
            exp_col_q.push_back(j);
            exp_cls_q.push_back(ref_class(j));
        end
        @(posedge clk); #2;
        mirror = mir;
        run    = 1'b1;
        for (int k = 0; k < npix * 6 + extra; k++) begin
            @(posedge clk);
            if (k == flip_at) begin #2; mirror = ~mirror; end
        end
        #2;
        run = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(c1 == 1'b1, "R10", c1, 1);
        chk(c2 == 1'b0, "R10", c2, 0);
        chk(c3 == 1'b1, "R10", c3, 1);
        chk(rg == 1'b0, "R10", rg, 0);
        chk(pix_valid == 1'b0, "R10", pix_valid, 0);
        chk(col_idx == '0, "R10", col_idx, 0);
        @(posedge clk); #2;
        rst = 1'b0;
        repeat (5) @(posedge clk);
        // full line past its end, direction flipped mid-line (R3 ignored)
        run_line(1'b0, 1085, 0, 300);
        repeat (20) @(posedge clk);
        // mirrored line stopped mid-pixel (R8 hold)
        run_line(1'b1, 40, 3, -1);
        repeat (15) @(posedge clk);
        // short normal line restarts at column 0 (R9)
        run_line(1'b0, 12, 0, 40);
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(exp_col_q.size() == 0, "R5", exp_col_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule